// File: doc/BRIEF.md
# Memory Instruction Issue Policy Selector

This block sits beside a window of memory instructions held in age order. Each cycle it chooses the oldest instruction that may start, and reports it to the memory pipeline as a slot index and a valid flag. Every slot carries four flags: occupied, load-or-store type, address-ready and data-ready. Address readiness and data readiness are separate flags, so the address half and the data half of a store are tracked apart. The selector holds one issued flag per slot. The flag is set when the slot is granted and cleared when the slot leaves the window.

A two-bit mode input picks how strictly loads are ordered against older stores. Mode 0 is fully in order. Mode 1 allows loads to pass each other, but any pending store blocks them. Mode 2 allows a load once every older pending store has a known address. Mode 3 lets a load go as soon as its own operands are ready, and relies on a later violation check elsewhere. Stores always issue in order behind every older operation. The block does not perform the access, forwarding or recovery.

The age of a slot is its distance from the head pointer, counted with wrap-around. The window depth must be a power of two.

Top module: `mem_issue_sel`

## Requirements
- R1: After reset no slot counts as issued: a ready load in the head slot is granted at once under mode 0.
- R2: Mode 0 (`mode_i` = 2'd0): a load is granted only when every older occupied slot has issued.
- R3: Mode 1 (`mode_i` = 2'd1): a load is granted only when no older occupied, unissued store exists. Older unissued loads do not block it.
- R4: Mode 2 (`mode_i` = 2'd2): a load is granted only when every older occupied, unissued store has its address-ready bit set. Store data readiness has no effect.
- R5: Mode 3 (`mode_i` = 2'd3): a load is granted regardless of older stores.
- R6: In every mode, a store (`is_store_i` bit = 1) is granted only when its address-ready and data-ready bits are both set and every older occupied slot has issued.
- R7: Among eligible slots, the one with the smallest age is granted. Age is (slot − `head_i`) mod DEPTH.
- R8: A granted slot is marked issued at the next rising clock edge and is not granted again while it stays occupied. A cycle with its occupied bit low clears that mark.
- R9: A slot is never granted unless it is occupied, unissued and address-ready. For a load, this address-ready bit is its operand readiness.
- R10: The grant outputs follow the inputs combinationally in the same cycle. At most one slot is granted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Ordering policy, 0 to 3 |
| head_i | input | IDX_W | Slot holding the oldest instruction |
| valid_i | input | DEPTH | Slot occupied |
| is_store_i | input | DEPTH | Slot holds a store (1) or load (0) |
| addr_rdy_i | input | DEPTH | Address or operands known |
| data_rdy_i | input | DEPTH | Store data known |
| gnt_valid_o | output | 1 | A slot is granted this cycle |
| gnt_idx_o | output | IDX_W | Granted slot |

## Verification
The grant is combinational, so it is due in the same cycle that the inputs are applied. The bench drives the inputs just after a falling edge and compares the grant a few nanoseconds later, before the next rising edge. The issued mark takes effect at that rising edge. The bench's own issued model is updated there from the expected grant, and the mark shows up in the next vector's expected result. A sweep over every mode and head position applies pseudo-random slot patterns. Directed vectors cover reset, wrap-around and re-grant after a slot is freed.

// File: rtl/mis_pkg.sv
package mis_pkg;
  typedef enum logic [1:0] {
    POL_INORDER  = 2'd0,
    POL_LD_FREE  = 2'd1,
    POL_WAIT_ADR = 2'd2,
    POL_SPEC     = 2'd3
  } policy_e;

  localparam int unsigned F_VLD = 0;
  localparam int unsigned F_ST  = 1;
  localparam int unsigned F_ADR = 2;
  localparam int unsigned F_DAT = 3;
  localparam int unsigned F_ISS = 4;
  localparam int unsigned N_FLD = 5;
endpackage

// File: rtl/mis_rotate.sv
module mis_rotate #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] phys_i,
  input  logic [IDX_W-1:0] head_i,
  output logic [DEPTH-1:0] age_o
);
  // age_o[k] is the slot k places behind the head
  for (genvar k = 0; k < DEPTH; k++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src      = IDX_W'(k) + head_i;
    assign age_o[k] = phys_i[src];
  end
endmodule

// File: rtl/mis_elig.sv
module mis_elig
  import mis_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  policy_e          mode_i,
  input  logic [DEPTH-1:0] vld_i,
  input  logic [DEPTH-1:0] st_i,
  input  logic [DEPTH-1:0] adr_i,
  input  logic [DEPTH-1:0] dat_i,
  input  logic [DEPTH-1:0] iss_i,
  output logic [DEPTH-1:0] elig_o
);
  logic pend_any, pend_st, pend_st_noadr, live, ld_ok, st_ok;

  always_comb begin
    pend_any      = 1'b0;
    pend_st       = 1'b0;
    pend_st_noadr = 1'b0;
    elig_o        = '0;
    live          = 1'b0;
    ld_ok         = 1'b0;
    st_ok         = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      live = vld_i[k] & ~iss_i[k];
      unique case (mode_i)
        POL_INORDER:  ld_ok = ~pend_any;
        POL_LD_FREE:  ld_ok = ~pend_st;
        POL_WAIT_ADR: ld_ok = ~pend_st_noadr;
        default:      ld_ok = 1'b1;
      endcase
      st_ok     = dat_i[k] & ~pend_any;
      elig_o[k] = live & adr_i[k] & (st_i[k] ? st_ok : ld_ok);
      pend_any      = pend_any | live;
      pend_st       = pend_st | (live & st_i[k]);
      pend_st_noadr = pend_st_noadr | (live & st_i[k] & ~adr_i[k]);
    end
  end
endmodule

// File: rtl/mis_prio.sv
module mis_prio #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/mem_issue_sel.sv
module mem_issue_sel
  import mis_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] is_store_i,
  input  logic [DEPTH-1:0] addr_rdy_i,
  input  logic [DEPTH-1:0] data_rdy_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [DEPTH-1:0]              issued_q;
  logic [N_FLD-1:0][DEPTH-1:0]   phys_fld, age_fld;
  logic [DEPTH-1:0]              elig_age;
  logic                          found;
  logic [IDX_W-1:0]              age_idx;
  policy_e                       mode;

  assign mode = policy_e'(mode_i);

  assign phys_fld[F_VLD] = valid_i;
  assign phys_fld[F_ST]  = is_store_i;
  assign phys_fld[F_ADR] = addr_rdy_i;
  assign phys_fld[F_DAT] = data_rdy_i;
  assign phys_fld[F_ISS] = issued_q;

  for (genvar f = 0; f < N_FLD; f++) begin : g_fld
    mis_rotate #(.DEPTH(DEPTH)) u_rot (
      .phys_i (phys_fld[f]),
      .head_i (head_i),
      .age_o  (age_fld[f])
    );
  end

  mis_elig #(.DEPTH(DEPTH)) u_elig (
    .mode_i (mode),
    .vld_i  (age_fld[F_VLD]),
    .st_i   (age_fld[F_ST]),
    .adr_i  (age_fld[F_ADR]),
    .dat_i  (age_fld[F_DAT]),
    .iss_i  (age_fld[F_ISS]),
    .elig_o (elig_age)
  );

  mis_prio #(.DEPTH(DEPTH)) u_prio (
    .req_i   (elig_age),
    .found_o (found),
    .idx_o   (age_idx)
  );

  assign gnt_valid_o = found;
  assign gnt_idx_o   = age_idx + head_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        issued_q[i] <= valid_i[i] &
                       (issued_q[i] | (found && gnt_idx_o == IDX_W'(i)));
      end
    end
  end
endmodule

// File: rtl/mem_issue_sel_chk.sv
module mem_issue_sel_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [IDX_W-1:0] head_i,
  input logic [DEPTH-1:0] valid_i,
  input logic [DEPTH-1:0] is_store_i,
  input logic [DEPTH-1:0] addr_rdy_i,
  input logic [DEPTH-1:0] data_rdy_i,
  input logic [DEPTH-1:0] issued_q,
  input logic             gnt_valid_o,
  input logic [IDX_W-1:0] gnt_idx_o
);
  logic older_pend, older_pend_st, older_st_noadr, reached;
  logic [IDX_W-1:0] slot;

  always_comb begin
    older_pend     = 1'b0;
    older_pend_st  = 1'b0;
    older_st_noadr = 1'b0;
    reached        = 1'b0;
    slot           = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = IDX_W'(k) + head_i;
      if (slot == gnt_idx_o) reached = 1'b1;
      if (!reached && valid_i[slot] && !issued_q[slot]) begin
        older_pend = 1'b1;
        if (is_store_i[slot]) begin
          older_pend_st = 1'b1;
          if (!addr_rdy_i[slot]) older_st_noadr = 1'b1;
        end
      end
    end
  end

  p_gnt_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (valid_i[gnt_idx_o] && !issued_q[gnt_idx_o] && addr_rdy_i[gnt_idx_o]));

  p_store_rule_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && is_store_i[gnt_idx_o]) |-> (data_rdy_i[gnt_idx_o] && !older_pend));

  p_inorder_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && mode_i == 2'd0) |-> !older_pend);

  p_ld_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && mode_i == 2'd1 && !is_store_i[gnt_idx_o]) |-> !older_pend_st);

  p_wait_adr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && mode_i == 2'd2 && !is_store_i[gnt_idx_o]) |-> !older_st_noadr);

  p_mark_issued_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && valid_i[gnt_idx_o]) |=>
      (!valid_i[$past(gnt_idx_o)] || issued_q[$past(gnt_idx_o)]));
endmodule

bind mem_issue_sel mem_issue_sel_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .head_i      (head_i),
  .valid_i     (valid_i),
  .is_store_i  (is_store_i),
  .addr_rdy_i  (addr_rdy_i),
  .data_rdy_i  (data_rdy_i),
  .issued_q    (issued_q),
  .gnt_valid_o (gnt_valid_o),
  .gnt_idx_o   (gnt_idx_o)
);

// File: tb/mem_issue_sel_bench.sv
module mem_issue_sel_bench;
  localparam int D = 4;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = '0;
  logic [W-1:0] head = '0;
  logic [D-1:0] vld = '0, st = '0, adr = '0, dat = '0;
  logic         gv;
  logic [W-1:0] gi;

  int n_vec = 0, n_bad = 0;
  bit [D-1:0] ref_iss = '0;
  bit exp_v;
  int exp_i;
  bit [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  mem_issue_sel #(.DEPTH(D)) u_mem_issue_sel (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .head_i(head),
    .valid_i(vld), .is_store_i(st), .addr_rdy_i(adr), .data_rdy_i(dat),
    .gnt_valid_o(gv), .gnt_idx_o(gi)
  );

  // reference: walk slots from head, apply policy rules directly
  task automatic predict();
    bit any_p = 0, st_p = 0, st_na = 0;
    exp_v = 0; exp_i = 0;
    for (int k = 0; k < D; k++) begin
      int s = (int'(head) + k) % D;
      bit live = vld[s] && !ref_iss[s];
      bit ok;
      if (st[s]) ok = adr[s] && dat[s] && !any_p;
      else case (mode)
        2'd0: ok = adr[s] && !any_p;
        2'd1: ok = adr[s] && !st_p;
        2'd2: ok = adr[s] && !st_na;
        default: ok = adr[s];
      endcase
      if (live && ok && !exp_v) begin exp_v = 1; exp_i = s; end
      if (live) begin
        any_p = 1;
        if (st[s]) begin st_p = 1; if (!adr[s]) st_na = 1; end
      end
    end
  endtask

  function automatic string tag_of(bit is_st);
    if (is_st) return "R6";
    case (mode)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // inputs already driven after negedge; check before the rising edge, then step
  task automatic check(string req);
    #2;
    predict();
    n_vec++;
    if (gv !== exp_v || (exp_v && int'(gi) != exp_i)) begin
      n_bad++;
      $display("FAIL %s mode=%0d head=%0d vld=%b st=%b adr=%b dat=%b: got v=%0b i=%0d exp v=%0b i=%0d",
               req, mode, head, vld, st, adr, dat, gv, gi, exp_v, exp_i);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < D; i++)
      ref_iss[i] = vld[i] && (ref_iss[i] || (exp_v && exp_i == i));
  endtask

  task automatic drive(bit [1:0] m, bit [W-1:0] h, bit [D-1:0] v, bit [D-1:0] s,
                       bit [D-1:0] a, bit [D-1:0] d);
    @(negedge clk);
    mode = m; head = h; vld = v; st = s; adr = a; dat = d;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: load at head granted right after reset
    drive(2'd0, 2'd0, 4'b0001, 4'b0000, 4'b0001, 4'b0000);
    check("R1");
    // R8: slot 0 now issued, must not be granted again; slot 1 not ready
    drive(2'd3, 2'd0, 4'b0011, 4'b0000, 4'b0001, 4'b0000);
    check("R8");
    // R8: freeing slot 0 clears its mark, then it is granted again
    drive(2'd3, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    check("R8");
    drive(2'd3, 2'd0, 4'b0001, 4'b0000, 4'b0001, 4'b0000);
    check("R8");
    // R7: wrap, head=3; slots 3 and 0 both ready loads -> slot 3 first
    drive(2'd3, 2'd3, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    check("R7");
    drive(2'd3, 2'd3, 4'b1001, 4'b0000, 4'b1001, 4'b0000);
    check("R7");
    check("R7");
    // R9: unready load never granted
    drive(2'd3, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    check("R9");
    drive(2'd3, 2'd0, 4'b0001, 4'b0000, 4'b0000, 4'b0000);
    check("R9");
    // R4: older store has address but no data; younger load passes in mode 2
    drive(2'd2, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    check("R4");
    drive(2'd2, 2'd0, 4'b0011, 4'b0001, 4'b0011, 4'b0000);
    check("R4");
    // R3: same pattern blocked in mode 1
    drive(2'd1, 2'd0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    check("R3");
    drive(2'd1, 2'd0, 4'b0011, 4'b0001, 4'b0011, 4'b0000);
    check("R3");
    // R10 / sweep: every mode and head, pseudo-random slot patterns
    for (int m = 0; m < 4; m++) begin
      for (int h = 0; h < D; h++) begin
        for (int n = 0; n < 600; n++) begin
          bit [3:0] v4, s4, a4, d4;
          lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
          v4 = (n % 5 == 0) ? lfsr[3:0] : (vld | lfsr[3:0]);
          s4 = lfsr[7:4];
          a4 = lfsr[11:8] | lfsr[19:16];
          d4 = lfsr[15:12] | lfsr[23:20];
          drive(2'(m), 2'(h), v4, s4, a4, d4);
          #2; predict(); #0;
          check(exp_v ? tag_of(st[exp_i]) : "R10");
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule